// File: doc/BRIEF.md
# Sixteen-Opcode Execute Unit

This block is the execute stage of a small 16-bit CPU with sixteen registers. Each cycle it can take one instruction word together with the values already read from the three register fields (destination, first source, second source). From these it computes the value to write back, a write strobe and the destination index, and holds all three in one register stage.

Instructions are 16 bits wide. Bits [15:12] hold the opcode, [11:8] the destination index, [7:4] the first source and [3:0] the second source or a fill code. The immediate forms use [7:0] as an 8-bit signed constant. The unit computes results for the register-register arithmetic and logic group, an inverted signed set-less-than, two one-bit shifts, a full constant load, a high-byte constant load and an add-immediate. Stores, branches and jumps never write a register. For a load, the block writes the data that the memory side returns in the same cycle, and writes it only when that data is marked valid. The single word 0x7FFF is the halt instruction. It writes nothing, although its opcode is the same as the right shift.

Top module: `exec_unit`

## Requirements
- R1: While rst_ni is low, wb_en_o, wb_data_o and wb_idx_o are all zero.
- R2: Outputs change one clock after an input cycle. wb_idx_o equals bits [11:8] of the word that was accepted. When valid_i is low, wb_en_o is low in the next cycle.
- R3: Opcodes 0, 1, 2, 3 and 4 write Rs+Rt, Rs-Rt, Rs AND Rt, Rs OR Rt and Rs XOR Rt. Sum and difference are taken modulo 2^16.
- R4: Opcode 5 compares Rs and Rt as signed two's complement numbers. It writes 0 when Rs < Rt and 1 otherwise.
- R5: Opcode 6 writes Rs shifted left by one. Bit 0 is 0 when the code in [3:0] is 0, and 1 for any other code.
- R6: Opcode 7 (except 0x7FFF) writes Rs shifted right by one. Bit 15 is 0 when the code in [3:0] is 0, and the old Rs bit 15 for any other code.
- R7: The word 0x7FFF writes no register (wb_en_o stays low).
- R8: Opcode 0xA writes the sign extension of [7:0] to 16 bits.
- R9: Opcode 0xB writes {[7:0], Rd[7:0]}. The low byte of the destination value is kept.
- R10: Opcode 0xE writes Rd plus the sign extension of [7:0], modulo 2^16.
- R11: Opcodes 9 (store), 0xC and 0xD (conditional branches) and 0xF (jump) write nothing. Neither does any other unused opcode.
- R12: Opcode 8 (load) writes ld_data_i to Rd when ld_valid_i is high in the same cycle, and writes nothing when it is low.
- R13: When the accepted instruction is not a load, ld_valid_i and ld_data_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 16 | Instruction word |
| rs_val_i | input | 16 | Value of the register named by [7:4] |
| rt_val_i | input | 16 | Value of the register named by [3:0] |
| rd_val_i | input | 16 | Value of the register named by [11:8] |
| ld_valid_i | input | 1 | Load return data is valid this cycle |
| ld_data_i | input | 16 | Load return data |
| wb_en_o | output | 1 | Write-back strobe |
| wb_idx_o | output | 4 | Destination register index |
| wb_data_o | output | 16 | Write-back value |

## Verification
The load-return strobe is an independent input, so it can arrive in the same cycle as any instruction. The bench raises ld_valid_i with random data beside arithmetic, constant, shift and control words, and also beside loads. It expects that the returned data reaches the write-back only for opcode 8. The halt word shares its opcode with the right shift, so 0x7FFF is issued directly next to 0x7FFE and other shift words. The behavioural model is compared against the outputs on every clock, to confirm that only the halt word suppresses the write.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int XLEN   = 16;
  localparam int REG_AW = 4;
  localparam int IMM_W  = 8;
  localparam logic [XLEN-1:0] HALT_WORD = 16'h7FFF;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_AND = 4'h2, OP_OR   = 4'h3,
    OP_XOR  = 4'h4, OP_SLTN = 4'h5, OP_SHL = 4'h6, OP_SHR  = 4'h7,
    OP_LD   = 4'h8, OP_ST   = 4'h9, OP_LI  = 4'hA, OP_LIH  = 4'hB,
    OP_BZ   = 4'hC, OP_BNZ  = 4'hD, OP_ADDI = 4'hE, OP_JMP = 4'hF
  } op_e;

  typedef enum logic [1:0] {SRC_ALU, SRC_IMM, SRC_LD} wb_src_e;
endpackage

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int W = XLEN
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fill_i,
  output logic [W-1:0] res_o
);
  logic fill_nz;
  assign fill_nz = |fill_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      // inverted polarity: 0 when less
      OP_SLTN: res_o = ($signed(a_i) < $signed(b_i)) ? '0 : W'(1);
      OP_SHL:  res_o = {a_i[W-2:0], fill_nz};
      OP_SHR:  res_o = {fill_nz & a_i[W-1], a_i[W-1:1]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exec_imm.sv
module exec_imm
  import exec_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input  op_e           op_i,
  input  logic [W-1:0]  rd_i,
  input  logic [IW-1:0] imm_i,
  output logic [W-1:0]  res_o
);
  localparam int EXT_W = W - IW;

  logic [W-1:0] sext;
  assign sext = {{EXT_W{imm_i[IW-1]}}, imm_i};

  always_comb begin
    unique case (op_i)
      OP_LI:   res_o = sext;
      OP_LIH:  res_o = {imm_i, rd_i[EXT_W-1:0]};
      OP_ADDI: res_o = rd_i + sext;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exec_wen.sv
module exec_wen
  import exec_pkg::*;
(
  input  op_e     op_i,
  input  logic    halt_i,
  input  logic    ld_valid_i,
  output logic    wen_o,
  output wb_src_e src_o
);
  always_comb begin
    wen_o = 1'b0;
    src_o = SRC_ALU;
    unique case (op_i)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLTN, OP_SHL:
        wen_o = 1'b1;
      OP_SHR:  wen_o = ~halt_i;
      OP_LI, OP_LIH, OP_ADDI: begin
        wen_o = 1'b1;
        src_o = SRC_IMM;
      end
      OP_LD: begin
        wen_o = ld_valid_i;
        src_o = SRC_LD;
      end
      default: wen_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW,
  parameter int IW = IMM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  instr_i,
  input  logic [W-1:0]  rs_val_i,
  input  logic [W-1:0]  rt_val_i,
  input  logic [W-1:0]  rd_val_i,
  input  logic          ld_valid_i,
  input  logic [W-1:0]  ld_data_i,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_idx_o,
  output logic [W-1:0]  wb_data_o
);
  localparam int OP_LSB = W - 4;
  localparam int RD_LSB = OP_LSB - AW;

  op_e          op;
  logic         halt;
  logic         wen;
  wb_src_e      src;
  logic [W-1:0] alu_res, imm_res, wb_next;

  assign op   = op_e'(instr_i[W-1:OP_LSB]);
  assign halt = (instr_i == HALT_WORD);

  exec_alu #(.W(W)) u_alu (
    .op_i(op), .a_i(rs_val_i), .b_i(rt_val_i),
    .fill_i(instr_i[3:0]), .res_o(alu_res)
  );

  exec_imm #(.W(W), .IW(IW)) u_imm (
    .op_i(op), .rd_i(rd_val_i), .imm_i(instr_i[IW-1:0]), .res_o(imm_res)
  );

  exec_wen u_wen (
    .op_i(op), .halt_i(halt), .ld_valid_i(ld_valid_i),
    .wen_o(wen), .src_o(src)
  );

  always_comb begin
    unique case (src)
      SRC_IMM: wb_next = imm_res;
      SRC_LD:  wb_next = ld_data_i;
      default: wb_next = alu_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= valid_i & wen;
      if (valid_i) begin
        wb_idx_o  <= instr_i[RD_LSB +: AW];
        wb_data_o <= wb_next;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !wb_en_o); // R1
  AST_IDLE_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wb_en_o); // R2
  AST_IDX_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wb_idx_o == $past(instr_i[RD_LSB +: AW])); // R2
  AST_HALT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i == HALT_WORD) |=> !wb_en_o); // R7
  AST_CTRL_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[W-1:OP_LSB] inside {4'h9, 4'hC, 4'hD, 4'hF}) |=> !wb_en_o); // R11
  AST_LD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[W-1:OP_LSB] == 4'h8) |=> wb_en_o == $past(ld_valid_i)); // R12
  AST_LIH_LOW_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[W-1:OP_LSB] == 4'hB) |=>
      wb_data_o[IW-1:0] == $past(rd_val_i[IW-1:0])); // R9
endmodule

// File: tb/exec_unit_tb_top.sv
module exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0, rs_v = '0, rt_v = '0, rd_v = '0, ld_d = '0;
  logic        ld_v = 1'b0;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [15:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          exp_en;
  logic [3:0]  exp_idx;
  logic [15:0] exp_data;
  string       exp_tag;

  always #5 clk = ~clk;

  exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rs_val_i(rs_v), .rt_val_i(rt_v), .rd_val_i(rd_v),
    .ld_valid_i(ld_v), .ld_data_i(ld_d),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  function automatic string tag_of(input logic [15:0] w, input bit v, input bit lv);
    int op = int'(w[15:12]);
    if (!v) return "R2";
    if (w == 16'h7FFF) return "R7";
    if (op <= 4) return lv ? "R13" : "R3";
    case (op)
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R12";
      10: return "R8";
      11: return "R9";
      14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // behavioural reference
  task automatic model();
    int op = int'(instr[15:12]);
    int s  = int'(instr[3:0]);
    int imm = int'($signed(instr[7:0]));
    int a = int'(rs_v), b = int'(rt_v), d = int'(rd_v);
    int sa = int'($signed(rs_v)), sb = int'($signed(rt_v));
    int r = 0;
    bit en = 1;
    case (op)
      0: r = a + b;
      1: r = a - b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (sa < sb) ? 0 : 1;
      6: r = (a * 2) + ((s != 0) ? 1 : 0);
      7: begin
        r = a / 2;
        if (s != 0 && a >= 32768) r = r + 32768;
        if (instr == 16'h7FFF) en = 0;
      end
      8: begin r = int'(ld_d); en = ld_v; end
      10: r = imm;
      11: r = int'(instr[7:0]) * 256 + (d % 256);
      14: r = d + imm;
      default: en = 0;
    endcase
    exp_en   = valid && en;
    exp_idx  = instr[11:8];
    exp_data = r[15:0];
    exp_tag  = tag_of(instr, valid, ld_v);
  endtask

  task automatic compare();
    checks++;
    if (wb_en !== exp_en || (exp_en && (wb_data !== exp_data || wb_idx !== exp_idx))) begin
      errors++;
      $display("FAIL %s: en=%0b idx=%0h data=%04h expected en=%0b idx=%0h data=%04h",
               exp_tag, wb_en, wb_idx, wb_data, exp_en, exp_idx, exp_data);
    end
  endtask

  // drive at negedge, design samples at posedge, check at following negedge
  task automatic step(input bit v, input logic [15:0] w, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] d,
                      input bit lv, input logic [15:0] ld);
    valid = v; instr = w; rs_v = a; rt_v = b; rd_v = d; ld_v = lv; ld_d = ld;
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    valid = 1'b1; instr = 16'h0123; rs_v = 16'h1111; ld_v = 1'b1;
    @(negedge clk);
    checks++; // R1
    if (wb_en !== 1'b0 || wb_idx !== 4'h0 || wb_data !== 16'h0) begin
      errors++;
      $display("FAIL R1: en=%0b idx=%0h data=%04h expected 0/0/0000", wb_en, wb_idx, wb_data);
    end
    rst_n = 1'b1;
    valid = 1'b0; ld_v = 1'b0;
    @(negedge clk);

    // directed corners
    step(1, 16'h0312, 16'hFFFF, 16'h0002, 0, 0, 0);   // R3 add wrap
    step(1, 16'h1312, 16'h0000, 16'h0001, 0, 0, 0);   // R3 sub wrap
    step(1, 16'h4A12, 16'hF0F0, 16'h0FF0, 0, 1, 16'hDEAD); // R13
    step(1, 16'h5112, 16'h8000, 16'h0001, 0, 0, 0);   // R4 signed less -> 0
    step(1, 16'h5112, 16'h0001, 16'h8000, 0, 0, 0);   // R4 -> 1
    step(1, 16'h5112, 16'h1234, 16'h1234, 0, 0, 0);   // R4 equal -> 1
    step(1, 16'h6210, 16'h8001, 0, 0, 0, 0);          // R5 fill 0
    step(1, 16'h6219, 16'h8001, 0, 0, 0, 0);          // R5 fill any nonzero
    step(1, 16'h7210, 16'h8001, 0, 0, 0, 0);          // R6 logical
    step(1, 16'h7211, 16'h8001, 0, 0, 0, 0);          // R6 arithmetic
    step(1, 16'h7FFF, 16'h8001, 0, 0, 1, 16'h5555);   // R7 halt
    step(1, 16'h7FFE, 16'h8001, 0, 0, 0, 0);          // R6 next to halt
    step(1, 16'hA580, 0, 0, 16'h1234, 0, 0);          // R8 negative
    step(1, 16'hA57F, 0, 0, 16'h1234, 0, 0);          // R8 positive
    step(1, 16'hB589, 0, 0, 16'h331D, 0, 0);          // R9
    step(1, 16'hE6FF, 0, 0, 16'h0000, 0, 0);          // R10 -1 wrap
    step(1, 16'hE601, 0, 0, 16'hFFFF, 0, 0);          // R10 carry out
    step(1, 16'h9340, 0, 0, 16'h1, 1, 16'h1);         // R11 store
    step(1, 16'hC302, 0, 0, 0, 0, 0);                 // R11
    step(1, 16'hD302, 0, 0, 1, 0, 0);                 // R11
    step(1, 16'hF300, 0, 0, 1, 1, 16'h2);             // R11
    step(1, 16'h8740, 16'h1000, 0, 0, 0, 16'hBEEF);   // R12 no data
    step(1, 16'h8740, 16'h1000, 0, 0, 1, 16'hBEEF);   // R12 data
    step(0, 16'h0312, 1, 1, 0, 1, 16'h7);             // R2 idle

    // random mix, load strobe concurrent with everything
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w = 16'($urandom);
      if (i % 50 == 7) w = 16'h7FFF;
      step(($urandom % 8) != 0, w, 16'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 16'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule